// File: doc/BRIEF.md
# Bubble-Collapsing Elastic Pipeline

This block is a chain of storage stages that carries data words from an upstream producer to a downstream consumer, with a valid/ready handshake at each end. The producer may leave gaps. A word enters the chain on any cycle when both `inValid` and `inReady` are high. It leaves from the last stage on any cycle when both `outValid` and `outReady` are high.

The stages do not share a single enable. Each stage moves its contents forward whenever some slot between it and the exit can absorb them. That slot is either the exit itself, when the consumer is ready, or an empty stage further along. As a result, gaps left by the producer are closed while the consumer stalls, and the chain fills completely before it refuses new input. Word order is kept throughout. No word is lost and no word is repeated. The stage count and the word width are parameters.

Top module: `elastic_pipe`

## Requirements
- R1: A synchronous active-high reset empties every stage. In the first cycle after reset, `outValid` is 0 and `inReady` is 1.
- R2: While `outValid` is high and `outReady` is low, on the next cycle `outValid` stays high and `outData` is unchanged.
- R3: Starting from an empty chain with `outReady` held low, exactly STAGES words are accepted before `inReady` drops. This holds when the words are presented back to back and also when empty cycles separate them.
- R4: Words leave in exactly the order they were accepted, each exactly once, under any mix of input gaps and output stalls.
- R5: Whenever `outReady` is high, `inReady` is high in the same cycle. A full chain therefore takes one word in and gives one word out in the same cycle, which sustains one word per cycle.
- R6: `inReady` is low only when every stage holds a word and `outReady` is low.
- R7: A word accepted into an empty chain while `outReady` stays high shows up on `outValid`/`outData` after STAGES rising edges, counting the edge that accepted it.
- R8: From one cycle to the next, the number of words held changes by the input transfers minus the output transfers. A full chain that receives one word and releases one word in the same cycle is still full afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Producer offers a word |
| inReady | output | 1 | Chain can take a word this cycle |
| inData | input | DATA_W | Offered word |
| outValid | output | 1 | Last stage holds a word |
| outReady | input | 1 | Consumer takes the word this cycle |
| outData | output | DATA_W | Word in the last stage |

## Verification
The bench tries several input patterns. A single word sent into an empty chain with the consumer ready measures latency. Back-to-back words into a stalled chain are compared with words spaced by empty cycles into a stalled chain. These two cases yield the same accepted count only if gaps are really squeezed out, whereas a chain with one shared stall enable would accept fewer words in the spaced case. A full chain that sees simultaneous input and output separates true full throughput from a design that frees a slot only one cycle later. A long random mix of gaps and stalls, compared against a scoreboard queue, exposes any reordering, loss or duplication.

// File: rtl/elastic_pipe_pkg.sv
package elastic_pipe_pkg;

  // Per-stage strobes sent from the control to the datapath.
  typedef struct packed {
    logic capture;  // stage takes a valid word from its source this cycle
    logic hold;     // stage keeps its current word this cycle
  } stageStrobe_t;

endpackage

// File: rtl/elastic_pipe_ctrl.sv
module elastic_pipe_ctrl
  import elastic_pipe_pkg::*;
#(
  parameter int STAGES = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       inValid,
  input  logic                       outReady,
  output logic                       inReady,
  output logic                       outValid,
  output stageStrobe_t [STAGES-1:0]  strobes
);

  logic [STAGES-1:0] stageValid;
  logic [STAGES-1:0] slotOpen;   // stage can load from its source this cycle
  logic [STAGES-1:0] srcValid;   // valid flag of the word offered to each stage

  // A stage may load when the consumer is ready or any stage from here to
  // the exit is empty: a wide AND over the downstream valid flags.
  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : gOpen
      assign slotOpen[gi] = outReady | ~(&stageValid[STAGES-1:gi]);
      if (gi == 0) begin : gHead
        assign srcValid[gi] = inValid;
      end else begin : gBody
        assign srcValid[gi] = stageValid[gi-1];
      end
      assign strobes[gi].capture = slotOpen[gi] & srcValid[gi];
      assign strobes[gi].hold    = stageValid[gi] & ~slotOpen[gi];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      stageValid <= '0;
    end else begin
      for (int i = 0; i < STAGES; i++) begin
        if (slotOpen[i]) stageValid[i] <= srcValid[i];
      end
    end
  end

  assign inReady  = slotOpen[0];
  assign outValid = stageValid[STAGES-1];

  assert_reset_empty_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!outValid && inReady));

  assert_ready_passes_R5: assert property (@(posedge clk) disable iff (rst)
    outReady |-> inReady);

  assert_refuse_only_full_R6: assert property (@(posedge clk) disable iff (rst)
    !inReady |-> (outValid && !outReady && (&stageValid)));

  assert_count_conserved_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($countones(stageValid) ==
      $past($countones(stageValid)) + int'($past(inValid && inReady))
      - int'($past(outValid && outReady))));

endmodule

// File: rtl/elastic_pipe_data.sv
module elastic_pipe_data
  import elastic_pipe_pkg::*;
#(
  parameter int STAGES = 16,
  parameter int DATA_W = 200
) (
  input  logic                       clk,
  input  logic                       rst,
  input  stageStrobe_t [STAGES-1:0]  strobes,
  input  logic [DATA_W-1:0]          inData,
  output logic [DATA_W-1:0]          outData
);

  logic [DATA_W-1:0] stageData [STAGES];

  // Data registers load only when a valid word arrives; no reset needed.
  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : gStage
      if (gi == 0) begin : gHead
        always_ff @(posedge clk) begin
          if (strobes[gi].capture) stageData[gi] <= inData;
        end
      end else begin : gBody
        always_ff @(posedge clk) begin
          if (strobes[gi].capture) stageData[gi] <= stageData[gi-1];
        end
      end

      assert_stage_hold_R2: assert property (@(posedge clk) disable iff (rst)
        strobes[gi].hold |=> $stable(stageData[gi]));

      assert_hold_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(strobes[gi].hold && strobes[gi].capture));
    end
  endgenerate

  assign outData = stageData[STAGES-1];

endmodule

// File: rtl/elastic_pipe.sv
module elastic_pipe
  import elastic_pipe_pkg::*;
#(
  parameter int STAGES = 16,
  parameter int DATA_W = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData
);

  stageStrobe_t [STAGES-1:0] strobes;

  elastic_pipe_ctrl #(.STAGES(STAGES)) uCtrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strobes  (strobes)
  );

  elastic_pipe_data #(.STAGES(STAGES), .DATA_W(DATA_W)) uData (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .inData  (inData),
    .outData (outData)
  );

  assert_out_stall_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

endmodule

// File: tb/tb_elastic_pipe.sv
module tb_elastic_pipe;

  localparam int STAGES = 16;
  localparam int DATA_W = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic outReady = 1'b0;
  logic [DATA_W-1:0] inData = '0;
  logic inReady, outValid;
  logic [DATA_W-1:0] outData;

  int checks = 0;
  int fails = 0;
  int seq = 0;
  logic [DATA_W-1:0] expQ [$];

  always #10 clk = ~clk;  // 50 MHz

  elastic_pipe #(.STAGES(STAGES), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outData(outData)
  );

  function automatic logic [DATA_W-1:0] mkWord(input int s);
    return DATA_W'({8{(32'(s) * 32'h9E37_79B1) ^ 32'hA5A5_0000}});
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus; sampled 2 ns before the rising edge.
  task automatic step(input bit v, input bit r, output bit took);
    @(negedge clk);
    inValid  = v;
    inData   = mkWord(seq);
    outReady = r;
    #8;
    took = v && inReady;
    if (took) begin
      expQ.push_back(mkWord(seq));
      seq++;
    end
  endtask

  task automatic drain();
    bit t;
    repeat (STAGES + 3) step(1'b0, 1'b1, t);
    chk(expQ.size() == 0, "R4 all accepted words delivered", expQ.size(), 0);
    chk(!outValid, "R4 empty after drain", outValid, 0);
  endtask

  // Monitor: scoreboard compare on every output transfer (R4).
  always @(negedge clk) begin
    #8;
    if (!rst && outValid && outReady) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R4 unexpected output word", outData, '0);
      end else begin
        chk(outData == expQ[0], "R4 output order", outData, expQ[0]);
        void'(expQ.pop_front());
      end
    end
  end

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL R4 watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit t;
    int cnt;
    logic [DATA_W-1:0] held;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #8;
    chk(!outValid, "R1 outValid after reset", outValid, 0);
    chk(inReady, "R1 inReady after reset", inReady, 1);

    // R7: latency through an empty chain
    step(1'b1, 1'b1, t);
    chk(t, "R7 word accepted", t, 1);
    cnt = 0;
    do begin
      step(1'b0, 1'b1, t);
      cnt++;
    end while (!outValid && cnt < 4 * STAGES);
    chk(cnt == STAGES, "R7 latency in edges", cnt, STAGES);
    drain();

    // R3: back-to-back under stall
    cnt = 0;
    repeat (STAGES + 4) begin
      step(1'b1, 1'b0, t);
      cnt += int'(t);
    end
    chk(cnt == STAGES, "R3 back-to-back accepted", cnt, STAGES);
    chk(!inReady, "R6 refuses when full and stalled", inReady, 0);
    chk(outValid, "R6 full implies outValid", outValid, 1);

    // R2: output stall holds
    held = outData;
    repeat (3) begin
      step(1'b0, 1'b0, t);
      chk(outValid, "R2 outValid held", outValid, 1);
      chk(outData == held, "R2 outData held", outData, held);
    end

    // R5: full chain, simultaneous in and out each cycle
    repeat (STAGES) begin
      step(1'b1, 1'b1, t);
      chk(t, "R5 input taken while full and draining", t, 1);
    end
    step(1'b0, 1'b0, t);
    chk(!inReady, "R8 still full after paired transfers", inReady, 0);
    drain();

    // R3: spaced words under stall; gaps must be squeezed out
    cnt = 0;
    repeat (3 * STAGES) begin
      step(1'b1, 1'b0, t);
      cnt += int'(t);
      step(1'b0, 1'b0, t);
    end
    chk(cnt == STAGES, "R3 spaced words accepted", cnt, STAGES);
    chk(!inReady, "R6 refuses after spaced fill", inReady, 0);
    drain();

    // R4: random mix of gaps and stalls
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 3) != 0, ($urandom % 2) != 0, t);
      if (outReady) chk(inReady, "R5 inReady follows outReady", inReady, 1);
    end
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule